// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block works out the geometry of a page-buffered serial flash attached behind an external SPI byte engine. After reset, and again whenever `start_i` is pulsed while the block is idle, it drives a short command sequence through the engine and reports three things. The first is the number of pages. The second is the page size in bytes. The third is the number of bits a page number must be shifted left to form a device address. From the first two it also derives the total capacity in bytes.

Identification runs in two stages. It first issues the standard manufacturer/device ID read. When the manufacturer byte matches, it looks the two device bytes up in a small geometry map. Some parts can run with either a binary page size or a slightly larger extended page size, and for those a single status read settles which one is active. When the manufacturer byte does not match, the block falls back to an older scheme: it reads the status byte and decodes a density code held in its middle bits. A result is flagged either valid or unsupported. The geometry outputs hold their values until the next identification starts.

The byte engine is driven with a one-cycle request carrying the byte to send. The engine answers with a one-cycle done pulse carrying the byte it received. Chip select stays high for the whole command frame.

Top module: `sflash_geom_id`

## Requirements
- R1: While reset is held, `geom_valid_o`, `unsupported_o`, `spi_cs_o` and `spi_req_o` are 0, and once reset is released one identification runs without any `start_i` pulse.
- R2: An ID frame sends byte 0x9F and then three fill bytes of 0x00, capturing the three received bytes. A status frame sends 0xD7 and then one fill byte. `spi_req_o` is a single-cycle pulse issued only while `spi_cs_o` is high. `spi_cs_o` goes low for at least one cycle between frames.
- R3: When the first ID byte is 0x1F, the second ID byte selects the density: 0x22, 0x23, 0x24 and 0x25 give 512, 1024, 2048 and 4096 pages with a 256/264-byte page. 0x26 gives 4096 pages and 0x27 gives 8192 pages, both with a 512/528-byte page. 0x28 gives 8192 pages with a 1024/1056-byte page. In each case the third ID byte must be 0x00.
- R4: Every part in the R3 map also accepts a third ID byte of 0x01 for device byte 0x27, and every entry except device 0x27 with third byte 0x00 is dual-size. A dual-size part triggers one status read: status bit 0 = 1 selects the binary page size and 0 selects the extended one. Device 0x27 with third byte 0x00 uses the extended size with no status read.
- R5: A first ID byte of 0x1F with an unmapped device pair gives `unsupported_o` = 1 and issues no status read.
- R6: When the first ID byte is not 0x1F, the second and third ID bytes are ignored and one status read decodes status bits 5:2. Code 0011 gives 512 pages, 0101 gives 1024 and 0111 gives 2048, all with 264-byte pages. 1001 gives 4096×264. 1011 gives 4096×528. 1101 gives 8192×528. 1110 and 1111 give 8192×1056. Status bits 7, 6, 1 and 0 have no effect.
- R7: In the fallback path a status byte of 0x00 or 0xFF means no device is present and gives `unsupported_o` = 1.
- R8: In the fallback path any other status code gives `unsupported_o` = 1.
- R9: On a valid result, `addr_shift_o` is log2 of the binary page size, or that value plus 1 for the extended size. `total_bytes_o` equals `page_count_o` × `page_size_o`.
- R10: Results and geometry stay unchanged, and no bus activity occurs, until the next accepted `start_i`. A `start_i` pulse during a run is ignored.
- R11: `geom_valid_o` and `unsupported_o` are never both 1, and neither is 1 while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, starts an identification on release |
| start_i | input | 1 | Request a new identification (accepted when idle) |
| spi_cs_o | output | 1 | Chip select, high for the duration of a command frame |
| spi_req_o | output | 1 | One-cycle request to exchange one byte |
| spi_tx_o | output | 8 | Byte to send with the request |
| spi_done_i | input | 1 | One-cycle pulse: byte exchange finished |
| spi_rx_i | input | 8 | Received byte, valid with `spi_done_i` |
| geom_valid_o | output | 1 | Geometry outputs describe an identified part |
| unsupported_o | output | 1 | Last identification failed or found no device |
| page_count_o | output | PCNT_W | Number of pages |
| page_size_o | output | PSZ_W | Page size in bytes |
| addr_shift_o | output | SH_W | Page-number shift into the device address |
| total_bytes_o | output | TOT_W | Capacity in bytes |

## Verification
The bench walks every mapped device code through both status-bit values, plus the single-size part, the fallback codes with the don't-care status bits set, and the no-device patterns. A design that trusted a 0xFF status would report a large part where no chip is present. A design that ignored the third ID byte would accept the unmapped pair as a 4096-page part. One that kept reading status for the single-size part would show an extra status frame. It also checks that a start pulse during a run does not trigger a second run, and that idle results stay frozen while the modelled device changes underneath them.

// File: rtl/sfid_pkg.sv
package sfid_pkg;

   // Compact geometry class: pages = 2**pg_log2, page = (256 << sz_cls) (+ pad if extended)
   typedef struct packed {
      logic [3:0] pg_log2;
      logic [1:0] sz_cls;
      logic       binary;
   } geom_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_EVAL  = 2'd3
   } state_t;

endpackage

// File: rtl/sfid_jedec_map.sv
module sfid_jedec_map
   import sfid_pkg::*;
(
   input  logic [7:0] dev_hi_i,
   input  logic [7:0] dev_lo_i,
   output logic       hit_o,
   output logic       dual_o,
   output geom_t      geom_o
);

   always_comb begin
      hit_o  = 1'b0;
      dual_o = 1'b1;
      geom_o = '0;
      case (dev_hi_i)
         8'h22: begin geom_o.pg_log2 = 4'd9;  hit_o = (dev_lo_i == 8'h00); end
         8'h23: begin geom_o.pg_log2 = 4'd10; hit_o = (dev_lo_i == 8'h00); end
         8'h24: begin geom_o.pg_log2 = 4'd11; hit_o = (dev_lo_i == 8'h00); end
         8'h25: begin geom_o.pg_log2 = 4'd12; hit_o = (dev_lo_i == 8'h00); end
         8'h26: begin
            geom_o.pg_log2 = 4'd12;
            geom_o.sz_cls  = 2'd1;
            hit_o          = (dev_lo_i == 8'h00);
         end
         8'h27: begin
            geom_o.pg_log2 = 4'd13;
            geom_o.sz_cls  = 2'd1;
            hit_o          = (dev_lo_i == 8'h00) || (dev_lo_i == 8'h01);
            dual_o         = (dev_lo_i == 8'h01);
         end
         8'h28: begin
            geom_o.pg_log2 = 4'd13;
            geom_o.sz_cls  = 2'd2;
            hit_o          = (dev_lo_i == 8'h00);
         end
         default: hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/sfid_legacy_map.sv
module sfid_legacy_map
   import sfid_pkg::*;
(
   input  logic [7:0] status_i,
   output logic       hit_o,
   output geom_t      geom_o
);

   logic absent;
   logic code_ok;

   assign absent = (status_i == 8'h00) || (status_i == 8'hFF);
   assign hit_o  = code_ok && !absent;

   always_comb begin
      code_ok = 1'b1;
      geom_o  = '0;
      case (status_i[5:2])
         4'b0011: geom_o.pg_log2 = 4'd9;
         4'b0101: geom_o.pg_log2 = 4'd10;
         4'b0111: geom_o.pg_log2 = 4'd11;
         4'b1001: geom_o.pg_log2 = 4'd12;
         4'b1011: begin geom_o.pg_log2 = 4'd12; geom_o.sz_cls = 2'd1; end
         4'b1101: begin geom_o.pg_log2 = 4'd13; geom_o.sz_cls = 2'd1; end
         4'b1110,
         4'b1111: begin geom_o.pg_log2 = 4'd13; geom_o.sz_cls = 2'd2; end
         default: code_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/sfid_geom_calc.sv
module sfid_geom_calc
   import sfid_pkg::*;
#(
   parameter int PCNT_W     = 14,
   parameter int PSZ_W      = 11,
   parameter int SH_W       = 4,
   parameter int TOT_W      = 24,
   parameter int BASE_PAGE  = 256,
   parameter int BASE_SHIFT = 8,
   parameter int EXT_PAD    = 8
) (
   input  geom_t              geom_i,
   output logic [PCNT_W-1:0]  page_count_o,
   output logic [PSZ_W-1:0]   page_size_o,
   output logic [SH_W-1:0]    addr_shift_o,
   output logic [TOT_W-1:0]   total_bytes_o
);

   logic [PSZ_W-1:0] bin_sz;
   logic [PSZ_W-1:0] pad_sz;
   logic [TOT_W-1:0] tot_bin;
   logic [TOT_W-1:0] tot_pad;

   assign bin_sz        = PSZ_W'(BASE_PAGE) << geom_i.sz_cls;
   assign pad_sz        = geom_i.binary ? '0 : (PSZ_W'(EXT_PAD) << geom_i.sz_cls);
   assign page_size_o   = bin_sz + pad_sz;
   assign page_count_o  = PCNT_W'(1) << geom_i.pg_log2;
   assign addr_shift_o  = SH_W'(BASE_SHIFT) + SH_W'(geom_i.sz_cls) + SH_W'(!geom_i.binary);
   assign tot_bin       = TOT_W'(bin_sz) << geom_i.pg_log2;
   assign tot_pad       = TOT_W'(pad_sz) << geom_i.pg_log2;
   assign total_bytes_o = tot_bin + tot_pad;

endmodule

// File: rtl/sflash_geom_id.sv
module sflash_geom_id
   import sfid_pkg::*;
#(
   parameter int         PCNT_W    = 14,
   parameter int         PSZ_W     = 11,
   parameter int         SH_W      = 4,
   parameter int         TOT_W     = 24,
   parameter logic [7:0] MFR_ID    = 8'h1F,
   parameter logic [7:0] OPC_ID    = 8'h9F,
   parameter logic [7:0] OPC_STAT  = 8'hD7,
   parameter logic [7:0] FILL_BYTE = 8'h00,
   parameter bit         LEGACY_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   output logic              spi_cs_o,
   output logic              spi_req_o,
   output logic [7:0]        spi_tx_o,
   input  logic              spi_done_i,
   input  logic [7:0]        spi_rx_i,
   output logic              geom_valid_o,
   output logic              unsupported_o,
   output logic [PCNT_W-1:0] page_count_o,
   output logic [PSZ_W-1:0]  page_size_o,
   output logic [SH_W-1:0]   addr_shift_o,
   output logic [TOT_W-1:0]  total_bytes_o
);

   localparam int ID_LEN = 3;
   localparam int IDX_W  = $clog2(ID_LEN + 1);
   localparam logic [IDX_W-1:0] ID_LAST   = IDX_W'(ID_LEN);
   localparam logic [IDX_W-1:0] STAT_LAST = IDX_W'(1);

   if (PCNT_W < 14) begin : g_chk_pcnt
      $error("PCNT_W must hold 8192");
   end
   if (PSZ_W < 11) begin : g_chk_psz
      $error("PSZ_W must hold 1056");
   end
   if (SH_W < 4) begin : g_chk_sh
      $error("SH_W must hold 11");
   end
   if (TOT_W < 24) begin : g_chk_tot
      $error("TOT_W must hold the largest capacity");
   end

   state_t                  state_q;
   logic                    phase_q;     // 0: ID frame, 1: status frame
   logic                    legacy_q;
   logic                    pending_q;
   logic                    valid_q;
   logic                    unsup_q;
   logic [IDX_W-1:0]        idx_q;
   logic [ID_LEN-1:0][7:0]  id_q;
   logic [7:0]              stat_q;
   geom_t                   geom_q;

   logic                    jm_hit;
   logic                    jm_dual;
   geom_t                   jm_geom;
   logic                    lm_hit;
   geom_t                   lm_geom;
   logic [IDX_W-1:0]        frame_last;

   sfid_jedec_map u_jmap (
      .dev_hi_i (id_q[1]),
      .dev_lo_i (id_q[2]),
      .hit_o    (jm_hit),
      .dual_o   (jm_dual),
      .geom_o   (jm_geom)
   );

   if (LEGACY_EN) begin : g_legacy
      sfid_legacy_map u_lmap (
         .status_i (stat_q),
         .hit_o    (lm_hit),
         .geom_o   (lm_geom)
      );
   end else begin : g_no_legacy
      assign lm_hit  = 1'b0;
      assign lm_geom = '0;
   end

   sfid_geom_calc #(
      .PCNT_W (PCNT_W),
      .PSZ_W  (PSZ_W),
      .SH_W   (SH_W),
      .TOT_W  (TOT_W)
   ) u_calc (
      .geom_i        (geom_q),
      .page_count_o  (page_count_o),
      .page_size_o   (page_size_o),
      .addr_shift_o  (addr_shift_o),
      .total_bytes_o (total_bytes_o)
   );

   assign frame_last    = phase_q ? STAT_LAST : ID_LAST;
   assign spi_cs_o      = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
   assign spi_req_o     = (state_q == ST_ISSUE);
   assign spi_tx_o      = (idx_q != '0) ? FILL_BYTE : (phase_q ? OPC_STAT : OPC_ID);
   assign geom_valid_o  = valid_q;
   assign unsupported_o = unsup_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         phase_q   <= 1'b0;
         legacy_q  <= 1'b0;
         pending_q <= 1'b1;
         valid_q   <= 1'b0;
         unsup_q   <= 1'b0;
         idx_q     <= '0;
         id_q      <= '0;
         stat_q    <= '0;
         geom_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (pending_q || start_i) begin
                  pending_q <= 1'b0;
                  valid_q   <= 1'b0;
                  unsup_q   <= 1'b0;
                  phase_q   <= 1'b0;
                  legacy_q  <= 1'b0;
                  idx_q     <= '0;
                  state_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (spi_done_i) begin
                  if (idx_q != '0) begin
                     if (phase_q) stat_q <= spi_rx_i;
                     else         id_q[idx_q - 1'b1] <= spi_rx_i;
                  end
                  if (idx_q == frame_last) begin
                     state_q <= ST_EVAL;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_EVAL: begin
               state_q <= ST_IDLE;
               idx_q   <= '0;
               if (!phase_q) begin
                  if (id_q[0] != MFR_ID) begin
                     phase_q  <= 1'b1;
                     legacy_q <= 1'b1;
                     state_q  <= ST_ISSUE;
                  end else if (!jm_hit) begin
                     unsup_q <= 1'b1;
                  end else if (jm_dual) begin
                     phase_q <= 1'b1;
                     state_q <= ST_ISSUE;
                  end else begin
                     valid_q <= 1'b1;
                     geom_q  <= jm_geom;
                  end
               end else if (legacy_q) begin
                  if (lm_hit) begin
                     valid_q <= 1'b1;
                     geom_q  <= lm_geom;
                  end else begin
                     unsup_q <= 1'b1;
                  end
               end else begin
                  valid_q <= 1'b1;
                  geom_q  <= '{pg_log2: jm_geom.pg_log2, sz_cls: jm_geom.sz_cls, binary: stat_q[0]};
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sflash_geom_id_chk.sv
module sflash_geom_id_chk #(
   parameter int PCNT_W = 14,
   parameter int PSZ_W  = 11,
   parameter int SH_W   = 4,
   parameter int TOT_W  = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              spi_cs_o,
   input logic              spi_req_o,
   input logic              geom_valid_o,
   input logic              unsupported_o,
   input logic [PCNT_W-1:0] page_count_o,
   input logic [PSZ_W-1:0]  page_size_o,
   input logic [SH_W-1:0]   addr_shift_o,
   input logic [TOT_W-1:0]  total_bytes_o
);

   // R2
   req_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_req_o |-> spi_cs_o);

   // R2
   req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_req_o |=> !spi_req_o);

   // R11
   result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(geom_valid_o && unsupported_o));

   // R11
   quiet_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (geom_valid_o || unsupported_o) |-> !spi_cs_o);

   // R10
   geom_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      geom_valid_o |=> (!geom_valid_o ||
                        ($stable(page_count_o) && $stable(page_size_o) &&
                         $stable(addr_shift_o) && $stable(total_bytes_o))));

   // R9
   total_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      geom_valid_o |-> (total_bytes_o == TOT_W'(TOT_W'(page_count_o) * TOT_W'(page_size_o))));

   // R9
   shift_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      geom_valid_o |-> (((TOT_W'(1) << addr_shift_o) >= TOT_W'(page_size_o)) &&
                        ((TOT_W'(1) << (addr_shift_o - 1'b1)) < TOT_W'(page_size_o))));

endmodule

bind sflash_geom_id sflash_geom_id_chk #(
   .PCNT_W (PCNT_W),
   .PSZ_W  (PSZ_W),
   .SH_W   (SH_W),
   .TOT_W  (TOT_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .spi_cs_o      (spi_cs_o),
   .spi_req_o     (spi_req_o),
   .geom_valid_o  (geom_valid_o),
   .unsupported_o (unsupported_o),
   .page_count_o  (page_count_o),
   .page_size_o   (page_size_o),
   .addr_shift_o  (addr_shift_o),
   .total_bytes_o (total_bytes_o)
);

// File: tb/tb_sflash_geom_id.sv
module tb_sflash_geom_id;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 26;
   localparam int WD_LIMIT   = 100000;

   typedef struct packed {
      logic [7:0]  id0;
      logic [7:0]  id1;
      logic [7:0]  id2;
      logic [7:0]  st;
      logic        ok;
      logic [31:0] pages;
      logic [31:0] psize;
      logic [31:0] shift;
      logic [31:0] total;
      logic [3:0]  nstat;
      logic [3:0]  rq;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{8'h1F,8'h22,8'h00,8'h01,1'b1,32'd512, 32'd256, 32'd8, 32'd131072, 4'd1,4'd4},
      '{8'h1F,8'h22,8'h00,8'h00,1'b1,32'd512, 32'd264, 32'd9, 32'd135168, 4'd1,4'd4},
      '{8'h1F,8'h23,8'h00,8'h00,1'b1,32'd1024,32'd264, 32'd9, 32'd270336, 4'd1,4'd3},
      '{8'h1F,8'h24,8'h00,8'h01,1'b1,32'd2048,32'd256, 32'd8, 32'd524288, 4'd1,4'd3},
      '{8'h1F,8'h25,8'h00,8'h01,1'b1,32'd4096,32'd256, 32'd8, 32'd1048576,4'd1,4'd3},
      '{8'h1F,8'h26,8'h00,8'h00,1'b1,32'd4096,32'd528, 32'd10,32'd2162688,4'd1,4'd9},
      '{8'h1F,8'h26,8'h00,8'h01,1'b1,32'd4096,32'd512, 32'd9, 32'd2097152,4'd1,4'd9},
      '{8'h1F,8'h27,8'h00,8'h01,1'b1,32'd8192,32'd528, 32'd10,32'd4325376,4'd0,4'd4},
      '{8'h1F,8'h27,8'h01,8'h01,1'b1,32'd8192,32'd512, 32'd9, 32'd4194304,4'd1,4'd4},
      '{8'h1F,8'h28,8'h00,8'h00,1'b1,32'd8192,32'd1056,32'd11,32'd8650752,4'd1,4'd9},
      '{8'h1F,8'h28,8'h00,8'h01,1'b1,32'd8192,32'd1024,32'd10,32'd8388608,4'd1,4'd9},
      '{8'h1F,8'h29,8'h00,8'h01,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd0,4'd5},
      '{8'h1F,8'h25,8'h01,8'h01,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd0,4'd5},
      '{8'h00,8'h22,8'h00,8'h0D,1'b1,32'd512, 32'd264, 32'd9, 32'd135168, 4'd1,4'd6},
      '{8'hFF,8'h22,8'h00,8'h14,1'b1,32'd1024,32'd264, 32'd9, 32'd270336, 4'd1,4'd6},
      '{8'h7F,8'h22,8'h00,8'h9C,1'b1,32'd2048,32'd264, 32'd9, 32'd540672, 4'd1,4'd6},
      '{8'h1E,8'h22,8'h00,8'h24,1'b1,32'd4096,32'd264, 32'd9, 32'd1081344,4'd1,4'd6},
      '{8'h00,8'h22,8'h00,8'hAC,1'b1,32'd4096,32'd528, 32'd10,32'd2162688,4'd1,4'd6},
      '{8'h00,8'h22,8'h00,8'h35,1'b1,32'd8192,32'd528, 32'd10,32'd4325376,4'd1,4'd6},
      '{8'h00,8'h22,8'h00,8'h38,1'b1,32'd8192,32'd1056,32'd11,32'd8650752,4'd1,4'd6},
      '{8'h00,8'h22,8'h00,8'hBC,1'b1,32'd8192,32'd1056,32'd11,32'd8650752,4'd1,4'd6},
      '{8'h00,8'h22,8'h00,8'h00,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd1,4'd7},
      '{8'h00,8'h22,8'h00,8'hFF,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd1,4'd7},
      '{8'h00,8'h22,8'h00,8'h10,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd1,4'd8},
      '{8'h00,8'h22,8'h00,8'h04,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd1,4'd8},
      '{8'h00,8'h22,8'h00,8'h30,1'b0,32'd0,   32'd0,   32'd0, 32'd0,      4'd1,4'd8}
   };

   logic        clk;
   logic        rst_n;
   logic        start;
   logic        spi_cs;
   logic        spi_req;
   logic [7:0]  spi_tx;
   logic        spi_done;
   logic [7:0]  spi_rx;
   logic        g_valid;
   logic        g_unsup;
   logic [13:0] g_pages;
   logic [10:0] g_psize;
   logic [3:0]  g_shift;
   logic [23:0] g_total;

   sflash_geom_id dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .start_i       (start),
      .spi_cs_o      (spi_cs),
      .spi_req_o     (spi_req),
      .spi_tx_o      (spi_tx),
      .spi_done_i    (spi_done),
      .spi_rx_i      (spi_rx),
      .geom_valid_o  (g_valid),
      .unsupported_o (g_unsup),
      .page_count_o  (g_pages),
      .page_size_o   (g_psize),
      .addr_shift_o  (g_shift),
      .total_bytes_o (g_total)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // Device model state, written by the stimulus process only
   logic [7:0] m_id0, m_id1, m_id2, m_st;

   // Byte engine and device model, written by this process only
   int         fidx = 0;
   logic [7:0] fop = 8'h00;
   int         rsp_cnt = 0;
   logic [7:0] rsp_byte = 8'hFF;
   int         n_stat = 0;
   int         n_req = 0;
   int         bad_fill = 0;
   int         id_len_seen = -1;
   int         st_len_seen = -1;

   initial begin
      spi_done = 1'b0;
      spi_rx   = 8'h00;
   end

   always @(negedge clk) begin
      spi_done <= 1'b0;
      if (!spi_cs && fidx != 0) begin
         if (fop == 8'h9F) id_len_seen = fidx - 1;
         if (fop == 8'hD7) st_len_seen = fidx - 1;
         fidx = 0;
      end
      if (rsp_cnt > 0) begin
         rsp_cnt = rsp_cnt - 1;
         if (rsp_cnt == 0) begin
            spi_done <= 1'b1;
            spi_rx   <= rsp_byte;
         end
      end else if (spi_req) begin
         n_req = n_req + 1;
         if (fidx == 0) begin
            fop      = spi_tx;
            rsp_byte = 8'hFF;
            if (spi_tx == 8'hD7) n_stat = n_stat + 1;
         end else begin
            if (spi_tx != 8'h00) bad_fill = bad_fill + 1;
            if (fop == 8'h9F)
               rsp_byte = (fidx == 1) ? m_id0 : (fidx == 2) ? m_id1 : (fidx == 3) ? m_id2 : 8'hFF;
            else if (fop == 8'hD7)
               rsp_byte = m_st;
            else
               rsp_byte = 8'hFF;
         end
         fidx    = fidx + 1;
         rsp_cnt = 2;
      end
   end

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > WD_LIMIT) begin
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
         $finish;
      end
   end

   function automatic string rtag(input int k);
      case (k)
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         default: return "R?";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_done();
      int c = 0;
      while (!(g_valid || g_unsup) && c < 2000) begin
         @(negedge clk);
         c++;
      end
      chk("R11", "completion", longint'(c < 2000), 1);
   endtask

   task automatic load(input int i);
      m_id0 = VEC[i].id0;
      m_id1 = VEC[i].id1;
      m_id2 = VEC[i].id2;
      m_st  = VEC[i].st;
   endtask

   task automatic check_vec(input int i, input int ns_delta);
      string t = rtag(int'(VEC[i].rq));
      chk(t, $sformatf("vec%0d valid", i), longint'(g_valid), longint'(VEC[i].ok));
      chk(t, $sformatf("vec%0d unsupported", i), longint'(g_unsup), longint'(!VEC[i].ok));
      chk("R11", $sformatf("vec%0d exclusive", i), longint'(g_valid && g_unsup), 0);
      chk(t, $sformatf("vec%0d status reads", i), ns_delta, longint'(VEC[i].nstat));
      if (VEC[i].ok) begin
         chk(t, $sformatf("vec%0d pages", i), longint'(g_pages), longint'(VEC[i].pages));
         chk(t, $sformatf("vec%0d page size", i), longint'(g_psize), longint'(VEC[i].psize));
         chk("R9", $sformatf("vec%0d shift", i), longint'(g_shift), longint'(VEC[i].shift));
         chk("R9", $sformatf("vec%0d total", i), longint'(g_total), longint'(VEC[i].total));
      end
   endtask

   task automatic run_vec(input int i);
      int ns0;
      load(i);
      ns0 = n_stat;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      wait_done();
      check_vec(i, n_stat - ns0);
   endtask

   initial begin
      int r0, r1;
      rst_n = 1'b0;
      start = 1'b0;
      load(0);
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1", "reset valid", longint'(g_valid), 0);
      chk("R1", "reset unsupported", longint'(g_unsup), 0);
      chk("R1", "reset cs", longint'(spi_cs), 0);
      chk("R1", "reset req", longint'(spi_req), 0);
      rst_n = 1'b1;
      // R1: automatic run after reset, no start pulse
      wait_done();
      check_vec(0, n_stat);
      // R2: frame shapes and fill bytes
      chk("R2", "ID frame data bytes", id_len_seen, 3);
      chk("R2", "status frame data bytes", st_len_seen, 1);
      chk("R2", "fill byte errors", bad_fill, 0);
      chk("R2", "requests for dual-size run", n_req, 6);

      for (int i = 1; i < NV; i++) run_vec(i);

      // R10: results hold while idle, even if the device changes
      run_vec(9);
      r0 = n_req;
      m_id0 = 8'h00;
      m_st  = 8'h0C;
      repeat (60) @(negedge clk);
      chk("R10", "hold valid", longint'(g_valid), 1);
      chk("R10", "hold page size", longint'(g_psize), 1056);
      chk("R10", "hold pages", longint'(g_pages), 8192);
      chk("R10", "idle requests", n_req - r0, 0);

      // R10: start during a run is ignored
      load(9);
      r0 = n_req;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      wait_done();
      r1 = n_req;
      repeat (60) @(negedge clk);
      chk("R10", "requests in one run", r1 - r0, 6);
      chk("R10", "no second run", n_req - r1, 0);
      chk("R10", "result after busy start", longint'(g_total), 8650752);
      chk("R2", "fill byte errors at end", bad_fill, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule